// File: doc/BRIEF.md
# TDM Slot Serial Receiver

This block is the receive engine of a time-division-multiplexed codec link. It runs on the serial bit clock and samples one data bit per rising edge, most significant bit first. A frame is split into consecutive slots of equal length. The slot length is programmable from 1 to 16 bits, and a frame holds at most 16 slots. A 16-bit mask picks which slots are captured. For each captured slot the block hands a downstream buffer unit one 16-bit word, left-justified with zero fill, together with a one-cycle write strobe.

The frame timing comes from an internal frame sync generator. As master, the generator runs freely over a programmable number of slots and drives a one-bit frame pulse at the first bit of slot 0. As slave, the generator is reset by each incoming frame pulse, which may arrive at any point, including mid-frame. In both modes the block stops writing once the last enabled slot of the frame has been delivered, and resumes at the next frame pulse. A slot index output lets software find its place in the frame again after it has lost alignment.

Top module: `tdm_slot_rx`

## Requirements
- R1: While reset is asserted and until the first bit is sampled after reset, `rx_wr` and `fs_out` are 0, `cur_slot` is 0, and `rx_word` is 0.
- R2: Every slot is `cfg_word_len`+1 bits long (value 0 means 1 bit, value 15 means 16 bits). Bits are sampled on the rising clock edge, and the first bit of a slot is its most significant bit.
- R3: When the last bit of a slot whose `cfg_slot_en` bit (bit n for slot n) is 1 has been sampled, `rx_wr` is 1 for exactly the following cycle. In that cycle `rx_word` holds the slot's word and `cur_slot` holds the slot number. A slot whose enable bit is 0 produces no strobe.
- R4: `rx_word` is left-justified: the first received bit is at bit 15, and the 15-`cfg_word_len` low bits are 0.
- R5: With `cfg_master`=1, `fs_out` is 1 for one bit period at the first bit of slot 0 and repeats every (`cfg_word_len`+1)×(`cfg_frame_slots`+1) cycles, so a frame holds `cfg_frame_slots`+1 slots. `fs_in` has no effect in this mode.
- R6: With `cfg_master`=0, the bit sampled in the cycle where `fs_in` is 1 becomes bit 0 of slot 0, even in the middle of a frame. `fs_out` stays 0. Nothing is captured before the first `fs_in` pulse after reset.
- R7: After an enabled slot completes with no higher-numbered slot enabled in the mask, no further word is written until the next frame pulse, even if a higher slot is enabled later in that frame.
- R8: In slave mode a frame ends after slot 15. Bits that arrive after slot 15 and before the next `fs_in` pulse are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1: generate frame pulse, 0: follow `fs_in` |
| cfg_word_len | input | 4 | Slot length minus one, in bits |
| cfg_frame_slots | input | 4 | Master frame length minus one, in slots |
| cfg_slot_en | input | 16 | Capture enable, bit n for slot n |
| sdi | input | 1 | Serial data in |
| fs_in | input | 1 | External frame pulse (slave) |
| fs_out | output | 1 | Generated frame pulse (master) |
| rx_word | output | 16 | Left-justified received word |
| rx_wr | output | 1 | One-cycle write strobe for `rx_word` |
| cur_slot | output | 4 | Slot of the most recently sampled bit |

## Verification
The bench covers both extreme word lengths. At 1 bit a design with an off-by-one slot counter would merge or skip slots, and at 16 bits a wrong justification shift would drop or duplicate the top bit. It sends a frame pulse in the middle of a slot, where a receiver that does not restart would deliver shifted, garbled words. It enables a higher slot after the last enabled slot has finished, where a design that rechecks the mask would write an extra word. It also drives bits past slot 15 and random `fs_in` levels in master mode, where a leaky design would produce stray strobes or reset its frame.

// File: rtl/tdmrx_pkg.sv
package tdmrx_pkg;
  localparam int DATA_W    = 16;
  localparam int NUM_SLOTS = 16;
  localparam int LEN_W     = $clog2(DATA_W);
  localparam int SLOT_W    = $clog2(NUM_SLOTS);

  typedef logic [DATA_W-1:0]    word_t;
  typedef logic [LEN_W-1:0]     len_t;
  typedef logic [SLOT_W-1:0]    slot_t;
  typedef logic [SLOT_W:0]      slotx_t;   // one extra bit flags "past last slot"
  typedef logic [NUM_SLOTS-1:0] mask_t;

  // True when any slot numbered above s is enabled in mask.
  function automatic logic any_above(input mask_t mask, input slot_t s);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if ((i > int'(s)) && mask[i]) r = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/tdmrx_framer.sv
// Frame sync generator plus bit and slot counters.
// Produces the effective position of the bit being sampled this cycle.
module tdmrx_framer
  import tdmrx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  master,
  input  len_t  word_len,
  input  slot_t frame_slots,
  input  logic  fs_in,
  output logic  fs_out,
  output logic  start,
  output logic  live,
  output logic  first,
  output logic  last,
  output slot_t pos_slot
);
  len_t   bit_q, bit_d, pb;
  slotx_t slot_q, slot_d, ps;
  logic   armed_q, armed_d;
  logic   run_q;
  logic   gen_start;

  always_comb begin
    gen_start = (bit_q == '0) && (slot_q == '0);
    start     = master ? (run_q && gen_start) : fs_in;
    pb        = start ? '0 : bit_q;
    ps        = start ? '0 : slot_q;
    live      = master ? run_q : (start || (armed_q && !ps[SLOT_W]));
    last      = (pb >= word_len);
    first     = (pb == '0);
    bit_d     = bit_q;
    slot_d    = slot_q;
    armed_d   = armed_q | (start & ~master);
    if (live) begin
      if (last) begin
        bit_d = '0;
        if (master && (ps >= {1'b0, frame_slots})) slot_d = '0;
        else                                       slot_d = ps + 1'b1;
      end else begin
        bit_d  = pb + 1'b1;
        slot_d = ps;
      end
    end
  end

  assign pos_slot = ps[SLOT_W-1:0];
  assign fs_out   = master & run_q & gen_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q   <= '0;
      slot_q  <= '0;
      armed_q <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      bit_q   <= bit_d;
      slot_q  <= slot_d;
      armed_q <= armed_d;
      run_q   <= 1'b1;
    end
  end
endmodule

// File: rtl/tdmrx_shifter.sv
// Serial-to-parallel shifter with left justification.
module tdmrx_shifter
  import tdmrx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  live,
  input  logic  first,
  input  len_t  word_len,
  input  logic  sdi,
  output word_t just_word
);
  localparam len_t TOP_BIT = len_t'(DATA_W - 1);

  word_t sh_q, sh_d, full;
  len_t  shamt;

  always_comb begin
    // A new slot starts from an empty register so unused high bits stay zero.
    full      = first ? {{(DATA_W-1){1'b0}}, sdi} : {sh_q[DATA_W-2:0], sdi};
    sh_d      = live ? full : sh_q;
    shamt     = TOP_BIT - word_len;
    just_word = full << shamt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end
endmodule

// File: rtl/tdmrx_gate.sv
// Slot gating, end-of-frame stop and output registers.
module tdmrx_gate
  import tdmrx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  live,
  input  logic  last,
  input  logic  start,
  input  slot_t pos_slot,
  input  mask_t slot_en,
  input  word_t word_in,
  output logic  rx_wr,
  output word_t rx_word,
  output slot_t cur_slot
);
  logic  done_q, done_d, done_eff, slot_end, fire;
  logic  wr_q, wr_d;
  word_t word_q, word_d;
  slot_t cur_q, cur_d;

  always_comb begin
    done_eff = start ? 1'b0 : done_q;
    slot_end = live && last;
    fire     = slot_end && slot_en[pos_slot] && !done_eff;
    done_d   = done_eff;
    if (fire && !any_above(slot_en, pos_slot)) done_d = 1'b1;
    wr_d   = fire;
    word_d = fire ? word_in : word_q;
    cur_d  = live ? pos_slot : cur_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      wr_q   <= 1'b0;
      word_q <= '0;
      cur_q  <= '0;
    end else begin
      done_q <= done_d;
      wr_q   <= wr_d;
      word_q <= word_d;
      cur_q  <= cur_d;
    end
  end

  assign rx_wr    = wr_q;
  assign rx_word  = word_q;
  assign cur_slot = cur_q;
endmodule

// File: rtl/tdm_slot_rx.sv
// TDM slot serial receiver top.
module tdm_slot_rx
  import tdmrx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_master,
  input  logic [3:0]  cfg_word_len,
  input  logic [3:0]  cfg_frame_slots,
  input  logic [15:0] cfg_slot_en,
  input  logic        sdi,
  input  logic        fs_in,
  output logic        fs_out,
  output logic [15:0] rx_word,
  output logic        rx_wr,
  output logic [3:0]  cur_slot
);
  // Reset asserts asynchronously and is released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic  start, live, first, last;
  slot_t pos_slot;
  word_t just_word;

  tdmrx_framer u_framer (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .master      (cfg_master),
    .word_len    (cfg_word_len),
    .frame_slots (cfg_frame_slots),
    .fs_in       (fs_in),
    .fs_out      (fs_out),
    .start       (start),
    .live        (live),
    .first       (first),
    .last        (last),
    .pos_slot    (pos_slot)
  );

  tdmrx_shifter u_shifter (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .live      (live),
    .first     (first),
    .word_len  (cfg_word_len),
    .sdi       (sdi),
    .just_word (just_word)
  );

  tdmrx_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .live     (live),
    .last     (last),
    .start    (start),
    .pos_slot (pos_slot),
    .slot_en  (cfg_slot_en),
    .word_in  (just_word),
    .rx_wr    (rx_wr),
    .rx_word  (rx_word),
    .cur_slot (cur_slot)
  );
endmodule

// File: rtl/tdm_slot_rx_chk.sv
module tdm_slot_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_master,
  input logic [3:0]  cfg_word_len,
  input logic [3:0]  cfg_frame_slots,
  input logic [15:0] cfg_slot_en,
  input logic        fs_out,
  input logic [15:0] rx_word,
  input logic        rx_wr,
  input logic [3:0]  cur_slot
);
  logic [15:0] en_q;
  logic [3:0]  wl_q;
  logic [3:0]  fsl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      wl_q  <= '0;
      fsl_q <= '0;
    end else begin
      en_q  <= cfg_slot_en;
      wl_q  <= cfg_word_len;
      fsl_q <= cfg_frame_slots;
    end
  end

  // R3: a strobe only ever reports a slot that was enabled
  p_wr_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wr |-> en_q[cur_slot]);

  // R3: strobe lasts one cycle when slots are longer than one bit
  p_wr_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_wr && cfg_word_len != 4'd0) |=> !rx_wr);

  // R4: low bits below the word length are zero
  p_left_just_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wr |-> (((32'(rx_word) << (32'(wl_q) + 32'd1)) & 32'hFFFF) == 32'd0));

  // R5: master frame pulse is one bit wide unless the frame is one bit
  p_fs_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && fs_out && (cfg_word_len != 4'd0 || cfg_frame_slots != 4'd0)) |=> !fs_out);

  // R5: master writes stay inside the programmed frame
  p_slot_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && rx_wr) |-> (cur_slot <= fsl_q));

  // R6: slave mode never drives a frame pulse
  p_slave_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master |-> !fs_out);
endmodule

bind tdm_slot_rx tdm_slot_rx_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cfg_master      (cfg_master),
  .cfg_word_len    (cfg_word_len),
  .cfg_frame_slots (cfg_frame_slots),
  .cfg_slot_en     (cfg_slot_en),
  .fs_out          (fs_out),
  .rx_word         (rx_word),
  .rx_wr           (rx_wr),
  .cur_slot        (cur_slot)
);

// File: tb/tb_tdm_slot_rx.sv
`timescale 1ns/1ps
module tb_tdm_slot_rx;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_master;
  logic [3:0]  cfg_word_len;
  logic [3:0]  cfg_frame_slots;
  logic [15:0] cfg_slot_en;
  logic        sdi;
  logic        fs_in;
  logic        fs_out;
  logic [15:0] rx_word;
  logic        rx_wr;
  logic [3:0]  cur_slot;

  int errs = 0;
  int checks = 0;
  logic [15:0] sdat [0:15];
  logic [15:0] cap_w [0:63];
  logic [3:0]  cap_s [0:63];
  int ncap = 0;
  logic cap_on = 1'b0;

  always #2 clk = ~clk;

  tdm_slot_rx dut (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_word_len(cfg_word_len),
    .cfg_frame_slots(cfg_frame_slots), .cfg_slot_en(cfg_slot_en), .sdi(sdi),
    .fs_in(fs_in), .fs_out(fs_out), .rx_word(rx_word), .rx_wr(rx_wr), .cur_slot(cur_slot)
  );

  always @(negedge clk) begin
    if (cap_on && rx_wr) begin
      if (ncap < 64) begin
        cap_w[ncap] = rx_word;
        cap_s[ncap] = cur_slot;
      end
      ncap++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input logic [15:0] d, input int w);
    int full;
    full = int'(d) & ((1 << (w + 1)) - 1);
    return 16'((full << (15 - w)) & 32'hFFFF);
  endfunction

  task automatic do_reset(input bit m, input int w, input int f, input logic [15:0] msk);
    rst_n = 1'b0;
    cfg_master = m;
    cfg_word_len = 4'(w);
    cfg_frame_slots = 4'(f);
    cfg_slot_en = msk;
    sdi = 1'b0;
    fs_in = 1'b0;
    repeat (3) @(negedge clk);
    chk(rx_wr == 1'b0 && fs_out == 1'b0 && cur_slot == 4'd0 && rx_word == 16'd0,
        "R1 reset outputs", {rx_wr, fs_out, cur_slot}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic fill_data(input int nsl);
    for (int s = 0; s < 16; s++) sdat[s] = (s < nsl) ? 16'($urandom) : 16'd0;
  endtask

  // Caller is positioned at a falling edge; the first bit is driven there.
  task automatic drive_frame(input int w, input int nsl, input bit slave, input bit clr,
                             input int chg_slot, input logic [15:0] chg_mask, input int idle);
    for (int s = 0; s < nsl; s++) begin
      for (int i = 0; i <= w; i++) begin
        if (!(s == 0 && i == 0)) @(negedge clk);
        sdi = sdat[s][w - i];
        fs_in = slave ? (s == 0 && i == 0) : 1'($urandom);
        if (s == chg_slot && i == 0) cfg_slot_en = chg_mask;
        if (s == 0 && i == 0) begin
          #1;
          if (clr) ncap = 0;
          cap_on = 1'b1;
        end
      end
    end
    for (int k = 0; k < idle; k++) begin
      @(negedge clk);
      sdi = 1'($urandom);
      fs_in = 1'b0;
    end
    @(negedge clk);
    #1;
    cap_on = 1'b0;
    fs_in = 1'b0;
  endtask

  task automatic check_frame(input logic [15:0] msk, input int w, input int nsl, input string tag);
    int k;
    int nexp;
    nexp = 0;
    for (int s = 0; s < nsl; s++) if (msk[s]) nexp++;
    chk(ncap == nexp, {"R3 write count ", tag}, ncap, nexp);
    k = 0;
    for (int s = 0; s < nsl; s++) begin
      if (msk[s] && k < ncap && k < 64) begin
        chk(cap_w[k] == exp_word(sdat[s], w), {"R2/R4 word ", tag}, cap_w[k], exp_word(sdat[s], w));
        chk(cap_s[k] == 4'(s), {"R3 slot index ", tag}, cap_s[k], s);
        k++;
      end
    end
  endtask

  task automatic master_run(input int w, input int f, input logic [15:0] msk);
    int n;
    do_reset(1'b1, w, f, msk);
    while (!fs_out) @(negedge clk);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!fs_out && n < 400);
    chk(n == (w + 1) * (f + 1), "R5 frame period", n, (w + 1) * (f + 1));
    fill_data(f + 1);
    drive_frame(w, f + 1, 1'b0, 1'b1, -1, 16'd0, 0);
    check_frame(msk, w, f + 1, "master");
  endtask

  task automatic slave_run(input int w, input logic [15:0] msk);
    cfg_word_len = 4'(w);
    cfg_slot_en = msk;
    fill_data(16);
    @(negedge clk);
    drive_frame(w, 16, 1'b1, 1'b1, -1, 16'd0, 20);
    check_frame(msk, w, 16, "slave");
    chk(fs_out == 1'b0, "R6 slave fs_out low", fs_out, 0);
  endtask

  initial begin
    #1_000_000;
    errs++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));

    // R1 and R6: no capture before the first frame pulse in slave mode
    do_reset(1'b0, 7, 0, 16'hFFFF);
    @(negedge clk);
    #1;
    ncap = 0;
    cap_on = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      sdi = 1'($urandom);
    end
    @(negedge clk);
    #1;
    cap_on = 1'b0;
    chk(ncap == 0, "R6 quiet before first pulse", ncap, 0);
    chk(cur_slot == 4'd0 && rx_wr == 1'b0, "R1 idle outputs", cur_slot, 0);

    // R2/R8: extreme word lengths, all slots, bits past slot 15 ignored
    slave_run(0, 16'hFFFF);
    slave_run(15, 16'hFFFF);
    slave_run(0, 16'h8001);

    // Random slave frames
    for (int t = 0; t < 6; t++) begin
      logic [15:0] m;
      m = 16'($urandom);
      if (m == 16'd0) m = 16'h0100;
      slave_run(int'($urandom % 16), m);
    end

    // R6: frame pulse arriving mid-slot restarts the frame
    cfg_word_len = 4'd7;
    cfg_slot_en = 16'h00F0;
    @(negedge clk);
    #1;
    ncap = 0;
    cap_on = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      sdi = 1'($urandom);
      fs_in = (k == 0);
    end
    fill_data(16);
    @(negedge clk);
    drive_frame(7, 16, 1'b1, 1'b0, -1, 16'd0, 4);
    check_frame(16'h00F0, 7, 16, "R6 resync");

    // R7: enabling a higher slot after the last enabled one has no effect this frame
    cfg_word_len = 4'd3;
    cfg_slot_en = 16'h0004;
    fill_data(16);
    @(negedge clk);
    drive_frame(3, 16, 1'b1, 1'b1, 3, 16'h0024, 4);
    check_frame(16'h0004, 3, 16, "R7 stop after last");
    fill_data(16);
    @(negedge clk);
    drive_frame(3, 16, 1'b1, 1'b1, -1, 16'd0, 4);
    check_frame(16'h0024, 3, 16, "R7 next frame");

    // R5: master mode, random fs_in ignored
    master_run(0, 0, 16'h0001);
    master_run(15, 15, 16'hA5C3);
    master_run(3, 5, 16'h0029);
    for (int t = 0; t < 3; t++) begin
      master_run(int'($urandom % 16), int'($urandom % 16), 16'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule